// File: doc/BRIEF.md
# Segment-Scanned Hex Display Driver

This block shows a 16-bit value as four hexadecimal characters on a four-digit common-cathode seven-segment display. The display's segment lines are shared by all four digits. Most drivers scan one digit at a time. This one scans one segment at a time. In each step a single segment anode line is driven. All four cathodes are then set together, and a digit's cathode is pulled low when that digit's glyph uses the active segment. At most one LED per digit is lit at any moment.

The value enters through a transparent latch controlled by a latch-enable input. At the start of every scan the latched value is copied into a snapshot register. A scan is the sweep from segment a through segment g. Because the digits shown during a scan all come from one snapshot, the display cannot tear mid-scan. A scan-enable input gates each step, so an external prescaler sets the refresh rate. The segment and cathode outputs are both registered and change on the same clock edge.

Top module: `segscan_hex_display`

## Requirements
- R1: While `rst_n` is low, `seg_line` is 7'b0000001 (segment a) and `cath_n` is 4'b1111 (all digits dark). The snapshot is cleared to 16'h0000, so the steps that follow reset, up to the first return to segment a, show four zeros.
- R2: Display digit k shows bits [4k+3:4k] of the value, and `cath_n[k]` drives digit k. Digit 0 uses bits 3:0; digit 3 uses bits 15:12.
- R3: Glyphs are listed here as segments a..g, most significant first, with 1 meaning lit. 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=1011111, 7=1110000, 8=1111111, 9=1110011, A=1110111, b=0011111, C=1001110, d=0111101, E=1001111, F=1000111.
- R4: Exactly one bit of `seg_line` is high at all times. `seg_line[0]` is segment a and `seg_line[6]` is segment g.
- R5: On a rising clock edge with `scan_en` high, the active segment advances a→b→c→d→e→f→g and then wraps from g back to a. With `scan_en` low, `seg_line` and `cath_n` hold their values.
- R6: After each advance, `cath_n[k]` is 0 exactly when digit k's glyph in the snapshot lights the segment now on `seg_line`. `cath_n` updates on the same edge as `seg_line`.
- R7: The latch follows `value_in` while `latch_en` is high and holds while it is low. Changes on `value_in` with `latch_en` low never reach the display.
- R8: The snapshot reloads from the latch only on the advance that enters segment a. A latch update in the middle of a scan appears only from the next scan on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Advance the scan one segment on this edge |
| latch_en | input | 1 | Transparent latch enable, high passes data |
| value_in | input | 16 | Value to display, four hex digits |
| seg_line | output | 7 | One-hot segment anode drive, bit 0 = a |
| cath_n | output | 4 | Active-low digit cathodes, bit k = digit k |

## Verification
On every cycle, the assertions check that the segment drive stays one-hot and that both outputs freeze while the scan is paused. They also check that an enabled step from g lands on a, and that the snapshot changes only as the scan enters a. Two things cannot be seen by the assertions and are shown only by the bench's scenarios against its own glyph model: the correctness of every glyph on every segment, and the boundary between latch writes and snapshot loads.

// File: rtl/ssd_pkg.sv
package ssd_pkg;

  parameter int unsigned SEG_COUNT = 7;
  parameter int unsigned NIBBLE_W  = 4;

  typedef logic [SEG_COUNT-1:0] seg_vec_t;

  // Glyph returned a..g with segment a in the most significant bit.
  function automatic seg_vec_t glyph_msb_a(input logic [NIBBLE_W-1:0] h);
    seg_vec_t g;
    unique case (h)
      4'h0: g = 7'b1111110;
      4'h1: g = 7'b0110000;
      4'h2: g = 7'b1101101;
      4'h3: g = 7'b1111001;
      4'h4: g = 7'b0110011;
      4'h5: g = 7'b1011011;
      4'h6: g = 7'b1011111;
      4'h7: g = 7'b1110000;
      4'h8: g = 7'b1111111;
      4'h9: g = 7'b1110011;
      4'hA: g = 7'b1110111;
      4'hB: g = 7'b0011111;
      4'hC: g = 7'b1001110;
      4'hD: g = 7'b0111101;
      4'hE: g = 7'b1001111;
      default: g = 7'b1000111;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/ssd_glyph_lookup.sv
module ssd_glyph_lookup
  import ssd_pkg::*;
(
  input  logic [NIBBLE_W-1:0] hex,
  output seg_vec_t            lit   // lit[i] = segment i, i=0 is a
);

  seg_vec_t msb_a;

  always_comb begin
    msb_a = glyph_msb_a(hex);
    for (int i = 0; i < int'(SEG_COUNT); i++) begin
      lit[i] = msb_a[SEG_COUNT-1-i];
    end
  end

endmodule

// File: rtl/ssd_seg_ring.sv
module ssd_seg_ring #(
  parameter int unsigned STEPS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [STEPS-1:0] step_q,
  output logic [STEPS-1:0] step_nxt,
  output logic             enter_first
);

  localparam logic [STEPS-1:0] FIRST = {{(STEPS-1){1'b0}}, 1'b1};

  always_comb begin
    if (adv) begin
      step_nxt = {step_q[STEPS-2:0], step_q[STEPS-1]};
    end else begin
      step_nxt = step_q;
    end
    enter_first = adv && step_q[STEPS-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= FIRST;
    end else begin
      step_q <= step_nxt;
    end
  end

  // R4
  ring_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(step_q) == 1);

endmodule

// File: rtl/ssd_value_hold.sv
module ssd_value_hold #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latch_en,
  input  logic [WIDTH-1:0] value_in,
  input  logic             load,
  output logic [WIDTH-1:0] snap_q,
  output logic [WIDTH-1:0] snap_nxt
);

  logic [WIDTH-1:0] lat_q;

  // Level-sensitive input latch: open while latch_en is high.
  always_latch begin
    if (latch_en) begin
      lat_q = value_in;
    end
  end

  always_comb begin
    if (load) begin
      snap_nxt = lat_q;
    end else begin
      snap_nxt = snap_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else begin
      snap_q <= snap_nxt;
    end
  end

  // R8
  snap_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_q != $past(snap_q)) |-> $past(load));

endmodule

// File: rtl/segscan_hex_display.sv
module segscan_hex_display
  import ssd_pkg::*;
#(
  parameter int unsigned DIGITS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         scan_en,
  input  logic                         latch_en,
  input  logic [DIGITS*NIBBLE_W-1:0]   value_in,
  output logic [SEG_COUNT-1:0]         seg_line,
  output logic [DIGITS-1:0]            cath_n
);

  localparam int unsigned VALUE_W = DIGITS * NIBBLE_W;

  logic [SEG_COUNT-1:0] step_q;
  logic [SEG_COUNT-1:0] step_nxt;
  logic                 enter_first;
  logic [VALUE_W-1:0]   snap_q;
  logic [VALUE_W-1:0]   snap_nxt;
  logic [DIGITS-1:0]    cath_nxt;
  logic [DIGITS-1:0]    cath_d;
  logic [DIGITS-1:0]    cath_q;

  ssd_seg_ring #(.STEPS(SEG_COUNT)) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (scan_en),
    .step_q     (step_q),
    .step_nxt   (step_nxt),
    .enter_first(enter_first)
  );

  ssd_value_hold #(.WIDTH(VALUE_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .latch_en(latch_en),
    .value_in(value_in),
    .load    (enter_first),
    .snap_q  (snap_q),
    .snap_nxt(snap_nxt)
  );

  for (genvar k = 0; k < int'(DIGITS); k++) begin : g_digit
    seg_vec_t lit;
    ssd_glyph_lookup u_glyph (
      .hex(snap_nxt[k*NIBBLE_W +: NIBBLE_W]),
      .lit(lit)
    );
    assign cath_nxt[k] = ~|(lit & step_nxt);
  end

  always_comb begin
    if (scan_en) begin
      cath_d = cath_nxt;
    end else begin
      cath_d = cath_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cath_q <= '1;
    end else begin
      cath_q <= cath_d;
    end
  end

  assign seg_line = step_q;
  assign cath_n   = cath_q;

  // R5
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> ($stable(seg_line) && $stable(cath_n)));

  // R5
  wrap_to_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && seg_line[SEG_COUNT-1]) |=> seg_line[0]);

  // R4
  seg_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(seg_line) && (seg_line != '0));

endmodule

// File: tb/segscan_hex_display_bench.sv
`timescale 1ns/1ps
module segscan_hex_display_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        scan_en;
  logic        latch_en;
  logic [15:0] value_in;
  logic [6:0]  seg_line;
  logic [3:0]  cath_n;

  int          checks = 0;
  int          fails  = 0;
  int          mstep;
  logic [15:0] mlat;
  logic [15:0] msnap;
  logic [3:0]  mcath;
  logic        finished = 1'b0;

  segscan_hex_display u_segscan_hex_display (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .latch_en(latch_en),
    .value_in(value_in), .seg_line(seg_line), .cath_n(cath_n)
  );

  always #2.5 clk = ~clk;

  function automatic logic [6:0] glyph(input logic [3:0] h);
    case (h)
      4'h0: return 7'b1111110;  4'h1: return 7'b0110000;
      4'h2: return 7'b1101101;  4'h3: return 7'b1111001;
      4'h4: return 7'b0110011;  4'h5: return 7'b1011011;
      4'h6: return 7'b1011111;  4'h7: return 7'b1110000;
      4'h8: return 7'b1111111;  4'h9: return 7'b1110011;
      4'hA: return 7'b1110111;  4'hB: return 7'b0011111;
      4'hC: return 7'b1001110;  4'hD: return 7'b0111101;
      4'hE: return 7'b1001111;  default: return 7'b1000111;
    endcase
  endfunction

  function automatic logic [3:0] exp_cath(input logic [15:0] v, input int st);
    logic [3:0] c;
    for (int k = 0; k < 4; k++) begin
      logic [6:0] g;
      g = glyph(v[k*4 +: 4]);
      c[k] = ~g[6-st];
    end
    return c;
  endfunction

  task automatic check_outs(input string tag_s, input string tag_c);
    logic [6:0] es;
    es = 7'b1 << mstep;
    checks++;
    if (seg_line !== es) begin
      fails++;
      $display("FAIL %s seg_line actual=%b expected=%b", tag_s, seg_line, es);
    end
    checks++;
    if (cath_n !== mcath) begin
      fails++;
      $display("FAIL %s cath_n actual=%b expected=%b", tag_c, cath_n, mcath);
    end
  endtask

  task automatic cycle(input logic en, input logic le, input logic [15:0] val,
                       input string tag_s, input string tag_c);
    @(negedge clk);
    scan_en  = en;
    latch_en = le;
    value_in = val;
    if (le) mlat = val;
    @(posedge clk);
    if (en) begin
      mstep = (mstep + 1) % 7;
      if (mstep == 0) msnap = mlat;
      mcath = exp_cath(msnap, mstep);
    end
    #1.25;
    check_outs(tag_s, tag_c);
  endtask

  // Run until the scan sits on segment a with the latch closed.
  task automatic run_to_a(input string tag);
    while (mstep != 0) cycle(1'b1, 1'b0, 16'h0000, "R4", tag);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed_val;
    seed_val = $urandom(32'h1F2E3D4C);
    rst_n = 1'b0; scan_en = 1'b0; latch_en = 1'b1; value_in = 16'h0000;
    mlat = 16'h0000; msnap = 16'h0000; mstep = 0; mcath = 4'hF;
    repeat (3) @(posedge clk);
    #1.25;
    check_outs("R1", "R1");          // reset state
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_outs("R1", "R1");

    // R1: snapshot cleared, first steps show zeros even with latch loaded
    cycle(1'b1, 1'b1, 16'h8888, "R5", "R1");
    cycle(1'b1, 1'b0, 16'h0000, "R5", "R1");
    run_to_a("R1");

    // R3/R2: every glyph on every segment, digits in distinct positions
    begin
      logic [15:0] vals [4];
      vals[0] = 16'h3210; vals[1] = 16'h7654; vals[2] = 16'hBA98; vals[3] = 16'hFEDC;
      for (int v = 0; v < 4; v++) begin
        cycle(1'b0, 1'b1, vals[v], "R5", "R3");
        for (int s = 0; s < 7; s++) cycle(1'b1, 1'b0, 16'h0000, "R4", "R3");
        for (int s = 0; s < 7; s++) cycle(1'b1, 1'b0, 16'h0000, "R4", "R2");
      end
    end

    // R5: pause holds both outputs
    cycle(1'b1, 1'b0, 16'h0000, "R5", "R5");
    cycle(1'b1, 1'b0, 16'h0000, "R5", "R5");
    for (int i = 0; i < 5; i++) cycle(1'b0, 1'b0, 16'h1234, "R5", "R5");
    run_to_a("R5");

    // R7: closed latch ignores value_in across a wrap
    for (int i = 0; i < 14; i++) cycle(1'b1, 1'b0, 16'h5A5A ^ 16'(i), "R4", "R7");

    // R8: mid-scan latch update waits for next scan
    cycle(1'b1, 1'b0, 16'h0000, "R4", "R8");
    cycle(1'b1, 1'b0, 16'h0000, "R4", "R8");
    cycle(1'b1, 1'b1, 16'h0F1E, "R4", "R8");
    for (int i = 0; i < 12; i++) cycle(1'b1, 1'b0, 16'h0000, "R4", "R8");

    // R6: random stimulus
    for (int i = 0; i < 600; i++) begin
      logic en, le;
      en = ($urandom % 4) != 0;
      le = ($urandom % 5) == 0;
      cycle(en, le, 16'($urandom), "R4", "R6");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule